// File: doc/BRIEF.md
# Inter-Stage Serial Test Access Wrapper

This block sits on the internal bus between two pipeline stages of a larger datapath. In mission operation the upstream stage's word goes straight to the downstream stage. When the test-mode pin is raised, the wrapper opens two serial paths around that bus. An observation path takes a parallel snapshot of the upstream word and sends it out one bit per clock on a single serial output. A control path gathers a word one bit per clock from a single serial input. That word goes to the downstream stage through a multiplexer.

Both serial paths run least significant bit first, so moving a W-bit word takes W clocks. A capture strobe takes the snapshot. An update strobe copies the gathered word into a holding register, and only the holding register drives the downstream stage. The downstream input therefore stays steady while bits are moving. All strobes and the serial input take effect only in test mode. The bus width is a parameter and defaults to 8.

Top module: `serial_test_wrapper`

## Requirements
- R1: While `rst_n` is low at a clock edge, the observation register, the gathering register and the holding register all clear to zero. In test mode with no strobes after reset, `s2_data` reads 0 and `tdo` reads 0.
- R2: With `test_mode` low, `s2_data` equals `s1_data` in the same cycle.
- R3: With `test_mode` low, `capture`, `shift`, `update` and `tdi` change no register. After a return to test mode, `tdo` and `s2_data` show the values held before.
- R4: In test mode, a clock edge with `capture` high loads `s1_data` into the observation register. `tdo` then shows bit 0 of the captured word.
- R5: In test mode, each edge with `shift` high and `capture` low moves the observation register one place toward bit 0 and fills the top bit with 0. After k shifts `tdo` shows bit k of the captured word, and after W shifts it shows 0.
- R6: In test mode, each edge with `shift` high moves `tdi` into the top bit of the gathering register. After W shifts, bit i holds the bit presented on shift number i, counted from 0. An edge with `update` high copies the gathering register into the holding register.
- R7: With `test_mode` high, `s2_data` equals the holding register. It does not change on any edge without `update`.
- R8: When `capture` and `shift` are both high on an edge in test mode, the capture takes effect and no shift happens.
- R9: When `update` and `shift` are both high on an edge in test mode, the holding register takes the contents the gathering register had before that shift.
- R10: With `test_mode` low, `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| test_mode | input | 1 | 1 selects test access, 0 selects mission pass-through |
| s1_data | input | W | Word from the upstream stage |
| s2_data | output | W | Word to the downstream stage |
| capture | input | 1 | Snapshot `s1_data` into the observation register |
| shift | input | 1 | Move both serial registers by one bit |
| update | input | 1 | Copy the gathered word to the holding register |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |

## Verification
Two pairs of actions can land on the same edge. A snapshot can coincide with a shift of the observation path, and an update can coincide with a shift of the control path. The bench raises each pair together on one edge. It judges the snapshot case by reading the next bits on `tdo`. It judges the update case by reading `s2_data` and comparing it with the pre-shift word, which differs from the post-shift word by the incoming bit. The normal-mode isolation is judged by leaving test mode with known state, toggling every test input, and returning to confirm that state.

// File: rtl/stw_pkg.sv
// Shared definitions for the serial test access wrapper.
// Assumes: nothing beyond IEEE 1800-2017.
package stw_pkg;
    // Operation applied to a serial register on one clock edge.
    typedef enum logic [1:0] {
        OP_KEEP  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } chain_op_t;
endpackage

// File: rtl/stw_capture_chain.sv
// Observation path: a parallel-load register that shifts toward bit 0.
// Bit 0 is the serial output. Load has priority over shift.
// Assumes: strobes are already qualified by test mode.
module stw_capture_chain
    import stw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic         shift_en,
    input  logic [W-1:0] par_in,
    output logic         ser_out
);
    logic [W-1:0] chain_q;
    chain_op_t    op;

    // Pick the operation: a snapshot beats a shift.
    always_comb begin
        if (load_en)       op = OP_LOAD;
        else if (shift_en) op = OP_SHIFT;
        else               op = OP_KEEP;
    end

    // Register update with zero fill at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            case (op)
                OP_LOAD:  chain_q <= par_in;
                OP_SHIFT: chain_q <= {1'b0, chain_q[W-1:1]};
                default:  chain_q <= chain_q;
            endcase
        end
    end

    assign ser_out = chain_q[0];
endmodule

// File: rtl/stw_load_chain.sv
// Control path: a serial-in register with bits entering at the top, plus a
// holding register that copies it on update.
// Assumes: strobes are already qualified by test mode.
module stw_load_chain #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         update_en,
    input  logic         ser_in,
    output logic [W-1:0] held
);
    logic [W-1:0] gather_q;
    logic [W-1:0] hold_q;

    // Serial gathering: the newest bit enters at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)        gather_q <= '0;
        else if (shift_en) gather_q <= {ser_in, gather_q[W-1:1]};
    end

    // Holding register: takes the gathered word as it stood before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= '0;
        else if (update_en) hold_q <= gather_q;
    end

    assign held = hold_q;
endmodule

// File: rtl/stw_apply_mux.sv
// Source selection for the downstream stage and gating of the serial output.
// Assumes: mode is steady for the cycle.
module stw_apply_mux #(
    parameter int W = 8
) (
    input  logic         mode,
    input  logic [W-1:0] mission,
    input  logic [W-1:0] injected,
    input  logic         ser_raw,
    output logic [W-1:0] to_next,
    output logic         ser_gated
);
    // Choose the downstream source and silence the serial pin off test.
    always_comb begin
        to_next   = mode ? injected : mission;
        ser_gated = mode & ser_raw;
    end
endmodule

// File: rtl/serial_test_wrapper.sv
// Test access wrapper around the bus between two pipeline stages.
// Observes the upstream word serially and injects a serially loaded word.
// Assumes: synchronous active-low reset and a single clock domain.
module serial_test_wrapper #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_mode,
    input  logic [W-1:0] s1_data,
    output logic [W-1:0] s2_data,
    input  logic         capture,
    input  logic         shift,
    input  logic         update,
    input  logic         tdi,
    output logic         tdo
);
    logic         cap_q, sh_q, upd_q;
    logic         obs_bit;
    logic [W-1:0] held_word;

    // Qualify every strobe with test mode so mission operation is untouched.
    always_comb begin
        cap_q = test_mode & capture;
        sh_q  = test_mode & shift;
        upd_q = test_mode & update;
    end

    stw_capture_chain #(.W(W)) i_obs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (cap_q),
        .shift_en (sh_q),
        .par_in   (s1_data),
        .ser_out  (obs_bit)
    );

    stw_load_chain #(.W(W)) i_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (sh_q),
        .update_en (upd_q),
        .ser_in    (tdi),
        .held      (held_word)
    );

    stw_apply_mux #(.W(W)) i_mux (
        .mode      (test_mode),
        .mission   (s1_data),
        .injected  (held_word),
        .ser_raw   (obs_bit),
        .to_next   (s2_data),
        .ser_gated (tdo)
    );
endmodule

// File: rtl/stw_checker.sv
// Port-level properties of the wrapper, attached by bind.
module stw_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         test_mode,
    input logic [W-1:0] s1_data,
    input logic [W-1:0] s2_data,
    input logic         capture,
    input logic         update,
    input logic         tdo
);
    logic armed;

    // Arms one edge after reset is released so $past sees valid history.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> s2_data == s1_data); // R2

    AST_TDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> !tdo); // R10

    AST_CAPTURE_BIT0: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (test_mode && capture) |=> (!test_mode || tdo == $past(s1_data[0]))); // R4

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (test_mode && $past(test_mode) && !$past(update) && $past(rst_n)) |-> $stable(s2_data)); // R7
endmodule

bind serial_test_wrapper stw_checker #(.W(W)) i_stw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .s1_data   (s1_data),
    .s2_data   (s2_data),
    .capture   (capture),
    .update    (update),
    .tdo       (tdo)
);

// File: tb/test_serial_test_wrapper.sv
module test_serial_test_wrapper;
    localparam int W = 8;
    localparam int NV = 6;
    // Each entry: {word on s1_data to observe, word to inject via tdi}.
    localparam logic [2*W-1:0] VEC [0:NV-1] = '{
        16'hA5_3C, 16'h01_80, 16'hFF_00, 16'h00_FF, 16'h96_69, 16'h7E_E7
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         test_mode = 1'b0;
    logic [W-1:0] s1_data = '0;
    logic [W-1:0] s2_data;
    logic         capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
    logic         tdo;
    int           n_cmp = 0, n_bad = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    serial_test_wrapper #(.W(W)) i_serial_test_wrapper (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .s1_data(s1_data),
        .s2_data(s2_data), .capture(capture), .shift(shift), .update(update),
        .tdi(tdi), .tdo(tdo)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        capture = 1'b0; shift = 1'b0; update = 1'b0; tdi = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] prev_hold;
        @(negedge clk);
        s1_data = 8'h3B;
        tick(); tick();
        rst_n = 1'b1;
        // R1 / R2 / R10: mission mode right after reset
        chk("R2", s2_data, 8'h3B);
        chk("R10", {7'b0, tdo}, 8'h00);
        test_mode = 1'b1;
        #1;
        chk("R1 hold cleared", s2_data, 8'h00);
        chk("R1 obs cleared", {7'b0, tdo}, 8'h00);
        prev_hold = '0;

        // Table walk: capture, shift out while shifting in, then update
        for (int v = 0; v < NV; v++) begin
            logic [W-1:0] obs, inj;
            obs = VEC[v][2*W-1:W];
            inj = VEC[v][W-1:0];
            s1_data = obs; capture = 1'b1;
            tick();
            capture = 1'b0;
            chk("R4", {7'b0, tdo}, {7'b0, obs[0]});
            for (int k = 0; k < W; k++) begin
                chk("R5", {7'b0, tdo}, {7'b0, obs[k]});
                shift = 1'b1; tdi = inj[k];
                tick();
                chk("R7", s2_data, prev_hold);
            end
            shift = 1'b0;
            chk("R5 zero fill", {7'b0, tdo}, 8'h00);
            update = 1'b1;
            tick();
            update = 1'b0;
            chk("R6", s2_data, inj);
            prev_hold = inj;
        end

        // R2 under several mission words
        test_mode = 1'b0;
        for (int k = 0; k < 4; k++) begin
            s1_data = 8'h11 << k;
            #1;
            chk("R2", s2_data, 8'h11 << k);
            tick();
        end

        // R3: load known state, leave test mode, toggle everything, come back
        test_mode = 1'b1; s1_data = 8'h81; capture = 1'b1;
        tick(); idle();
        test_mode = 1'b0; s1_data = 8'h5A;
        for (int k = 0; k < W + 2; k++) begin
            capture = 1'b1; shift = 1'b1; update = 1'b1; tdi = k[0];
            tick();
            chk("R10", {7'b0, tdo}, 8'h00);
        end
        idle();
        test_mode = 1'b1;
        #1;
        chk("R3 obs kept", {7'b0, tdo}, 8'h01);
        chk("R3 hold kept", s2_data, prev_hold);

        // R8: capture and shift together
        s1_data = 8'h03; capture = 1'b1; shift = 1'b1;
        tick(); idle();
        chk("R8 after", {7'b0, tdo}, 8'h01);
        shift = 1'b1; tick();
        chk("R8 bit1", {7'b0, tdo}, 8'h01);
        tick(); shift = 1'b0;
        chk("R8 bit2", {7'b0, tdo}, 8'h00);

        // R9: update and shift together take the pre-shift word
        for (int k = 0; k < W; k++) begin
            shift = 1'b1; tdi = (k >= 4);
            tick();
        end
        shift = 1'b1; update = 1'b1; tdi = 1'b1;
        tick(); idle();
        chk("R9", s2_data, 8'hF0);
        update = 1'b1;
        tick(); idle();
        chk("R9 post-shift", s2_data, 8'hF8);

        // R1: reset in test mode clears everything
        s1_data = 8'hFF; capture = 1'b1; rst_n = 1'b0;
        tick(); idle();
        rst_n = 1'b1;
        #1;
        chk("R1 hold", s2_data, 8'h00);
        chk("R1 obs", {7'b0, tdo}, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule